// File: doc/BRIEF.md
# Length-Counted FIFO SPI Master

This block is a half-duplex SPI master that moves a programmed number of bytes in one direction per transfer. Software presents a control word and a 21-bit byte count, then starts the transfer. The control word holds a serial clock divider code, a two-bit device number, a lane-width choice (one data line or four) and a direction (read from the device or write to it). Payload moves as 32-bit words through a one-word data register in each direction. A busy flag on that register tells software when it must wait before pushing or popping a word.

Each word is split into bytes, least significant byte first. Each byte goes out most significant bit first on one line, or as two nibbles (high nibble first) across four lines. The serial clock idles low. Data changes on the falling edge and is sampled on the rising edge. If the data register is not ready, the shifter waits between bytes with the clock held low. When the byte count reaches zero the block pulses `done` for an interrupt unit. The chip select stays asserted afterwards until software clears it with a separate strobe.

Top module: `fifo_spi_master`

## Requirements
- R1: A cycle with `cfg_we` high and `cfg_ctrl[15]` high while idle starts a transfer. It captures the divider code `cfg_ctrl[2:0]`, the device `cfg_ctrl[7:6]`, the lane width `cfg_ctrl[12]` (1 = four lanes) and the direction `cfg_ctrl[13]` (1 = write), together with the byte count `cfg_len`. `busy` reads 1 from the next cycle until the transfer ends. A start request while busy is ignored, including its byte count.
- R2: `sclk` is low whenever the block is idle. Within a byte, a divider code n gives an `sclk` period of 2^(n+1) system clock cycles. Output data changes only on falling edges and input data is sampled on rising edges.
- R3: In one-lane mode, byte i of a transfer is byte i mod 4 (least significant byte first) of word i/4. It is shifted MSB first: in write mode it is driven on `sio_out[0]`, and in read mode it is sampled from `sio_in[1]`.
- R4: In four-lane mode each byte takes two `sclk` periods, high nibble first. Writes drive `sio_out[3:0]` and reads sample `sio_in[3:0]`.
- R5: Exactly `cfg_len` bytes are clocked. The bytes of the last written word beyond the count are never sent. Read words pack received bytes least significant first, and the byte slots beyond the count in the last read word are zero.
- R6: `fifo_busy` is 1 in write mode while a pushed word is not yet taken by the shifter, and 1 in read mode while no received word is waiting. After reset it is 1. The shifter holds `sclk` low until it has the next write word, or until the read register is free.
- R7: `done` is a single-cycle pulse in the cycle after the last byte's final falling edge, and `busy` is 0 in that same cycle. A count of zero gives `done` in the second cycle after the start, with no `sclk` edge.
- R8: From the start, `cs_n[dev]` is low and the other three `cs_n` lines are high, and `cs_active` is 1. Both remain so after `done` until a `cs_clr` pulse while idle. A `cs_clr` pulse while busy has no effect.
- R9: `sio_oe` is 4'hF for a four-lane write, 4'h1 for a one-lane write, and 0 while reading or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_ctrl | input | 16 | Control word: divider, device, lanes, direction, start |
| cfg_len | input | 21 | Byte count captured at start |
| busy | output | 1 | Transfer in progress |
| cs_clr | input | 1 | Deselect strobe (the write of zero to chip select) |
| cs_active | output | 1 | Chip select currently asserted |
| fifo_busy | output | 1 | Software must wait before pushing/popping |
| data_push | input | 1 | Push `data_in` into the write word register |
| data_in | input | 32 | Write payload word |
| data_pop | input | 1 | Pop the received word |
| data_out | output | 32 | Received payload word |
| done | output | 1 | One-cycle transfer-complete pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low device selects |
| sio_out | output | 4 | Serial data out lanes |
| sio_oe | output | 4 | Output enables for the lanes |
| sio_in | input | 4 | Serial data in lanes |

## Verification
A wrong byte index or shift count inside the shifter shows up at the serial lanes within one byte time. The slave model then collects a misordered or misplaced byte, and the read word handed back differs from the packed expectation as soon as software pops it. A miscounted byte total appears at the end of the transfer, as too many or too few captured bytes or a `done` pulse that is missing or late. A corrupted divider shows up as a wrong rising-edge spacing within the first byte. A lost chip-select state shows on `cs_n` right after start, or on the check made between `done` and the deselect strobe.

// File: rtl/fifo_spi_master.sv
module fifo_spi_master #(
  parameter int LEN_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_ctrl,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             busy,
  input  logic             cs_clr,
  output logic             cs_active,
  output logic             fifo_busy,
  input  logic             data_push,
  input  logic [31:0]      data_in,
  input  logic             data_pop,
  output logic [31:0]      data_out,
  output logic             done,
  output logic             sclk,
  output logic [3:0]       cs_n,
  output logic [3:0]       sio_out,
  output logic [3:0]       sio_oe,
  input  logic [3:0]       sio_in
);
  logic             run, shifting, quad, wr, csel, wfull, rfull;
  logic [2:0]       div, steps;
  logic [1:0]       dev, idx;
  logic [6:0]       dcnt;
  logic [7:0]       sh, half;
  logic [LEN_W-1:0] left;
  logic [31:0]      wbuf, cur, rbuf, rx_word;
  logic             tick, can_go, last_step;

  assign half      = 8'd1 << div;
  assign tick      = ({1'b0, dcnt} == half - 8'd1);
  assign can_go    = (idx != 2'd0) || (wr ? wfull : !rfull);
  assign last_step = steps == (quad ? 3'd1 : 3'd7);

  always_comb begin
    rx_word = (idx == 2'd0) ? 32'd0 : cur;
    rx_word[8*idx +: 8] = sh;
  end

  assign busy      = run;
  assign cs_active = csel;
  assign cs_n      = csel ? ~(4'b0001 << dev) : 4'hF;
  assign fifo_busy = wr ? wfull : !rfull;
  assign data_out  = rbuf;
  assign sio_out   = (run && wr) ? (quad ? sh[7:4] : {3'b000, sh[7]}) : 4'h0;
  assign sio_oe    = (run && wr) ? (quad ? 4'hF : 4'h1) : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; shifting <= 1'b0; quad <= 1'b0; wr <= 1'b0; csel <= 1'b0;
      wfull <= 1'b0; rfull <= 1'b0; div <= 3'd0; steps <= 3'd0; dev <= 2'd0;
      idx <= 2'd0; dcnt <= 7'd0; sh <= 8'd0; left <= '0; wbuf <= 32'd0;
      cur <= 32'd0; rbuf <= 32'd0; done <= 1'b0; sclk <= 1'b0;
    end else begin
      done <= 1'b0;
      if (data_push && !wfull) begin
        wbuf  <= data_in;
        wfull <= 1'b1;
      end
      if (data_pop && rfull) rfull <= 1'b0;
      if (cs_clr && !run) csel <= 1'b0;
      if (!run) begin
        if (cfg_we && cfg_ctrl[15]) begin
          run  <= 1'b1;
          csel <= 1'b1;
          div  <= cfg_ctrl[2:0];
          dev  <= cfg_ctrl[7:6];
          quad <= cfg_ctrl[12];
          wr   <= cfg_ctrl[13];
          left <= cfg_len;
          idx  <= 2'd0;
          shifting <= 1'b0;
        end
      end else if (!shifting) begin
        if (left == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else if (can_go) begin
          shifting <= 1'b1;
          steps    <= 3'd0;
          dcnt     <= 7'd0;
          if (wr) begin
            if (idx == 2'd0) begin
              cur   <= wbuf;
              sh    <= wbuf[7:0];
              wfull <= 1'b0;
            end else begin
              sh <= cur[8*idx +: 8];
            end
          end
        end
      end else if (!tick) begin
        dcnt <= dcnt + 7'd1;
      end else begin
        dcnt <= 7'd0;
        if (!sclk) begin
          sclk <= 1'b1;
          if (!wr) sh <= quad ? {sh[3:0], sio_in} : {sh[6:0], sio_in[1]};
        end else begin
          sclk <= 1'b0;
          if (last_step) begin
            shifting <= 1'b0;
            idx  <= idx + 2'd1;
            left <= left - 1'b1;
            if (!wr) begin
              if (idx == 2'd3 || left == LEN_W'(1)) begin
                rbuf  <= rx_word;
                rfull <= 1'b1;
              end else begin
                cur <= rx_word;
              end
            end
          end else begin
            steps <= steps + 3'd1;
            if (wr) sh <= quad ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R8
  cs_during_run_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cs_active && cs_n != 4'hF));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);
  // R2
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && $rose(sclk)) |-> $stable(sio_out));
  // R1
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cfg_we && cfg_ctrl[15]));
  // R9
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n) (sio_oe != 4'h0) |-> busy);
endmodule

// File: tb/fifo_spi_master_tb.sv
`timescale 1ns/1ps
module fifo_spi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_ctrl = 16'd0;
  logic [20:0] cfg_len = 21'd0;
  logic        busy, cs_active, fifo_busy, done, sclk;
  logic        cs_clr = 1'b0, data_push = 1'b0, data_pop = 1'b0;
  logic [31:0] data_in = 32'd0, data_out;
  logic [3:0]  cs_n, sio_out, sio_oe;
  logic [3:0]  sio_in = 4'h0;

  fifo_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl), .cfg_len(cfg_len),
    .busy(busy), .cs_clr(cs_clr), .cs_active(cs_active), .fifo_busy(fifo_busy),
    .data_push(data_push), .data_in(data_in), .data_pop(data_pop), .data_out(data_out),
    .done(done), .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cap_n, nb, rise_n, rise_t0, rise_t1, rp, done_n, seed_x;
  bit x_quad, x_wr;
  logic [7:0]  acc;
  logic [7:0]  cap [0:63];
  logic [31:0] wdat [0:15];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] src(input int k);
    return 8'(k * 37 + seed_x);
  endfunction

  function automatic logic [3:0] chunk(input int p);
    logic [7:0] b;
    int o;
    b = src(p / 8);
    o = p % 8;
    if (x_quad) return (o < 4) ? b[7:4] : b[3:0];
    return {2'b00, b[7-o], 1'b0};
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (done) begin
      done_n++;
      check(!busy, "R7 busy low with done", busy, 0);
    end
  end

  initial forever begin
    @(posedge sclk);
    if (rise_n == 0) rise_t0 = cyc;
    if (rise_n == 1) rise_t1 = cyc;
    rise_n++;
    if (x_wr) begin
      if (x_quad) begin acc = {acc[3:0], sio_out}; nb += 4; end
      else begin acc = {acc[6:0], sio_out[0]}; nb += 1; end
      if (nb == 8) begin
        if (cap_n < 64) cap[cap_n] = acc;
        cap_n++;
        nb = 0;
      end
    end
  end

  initial forever begin
    @(negedge sclk);
    if (!x_wr) begin
      rp += x_quad ? 4 : 1;
      sio_in = chunk(rp);
    end
  end

  initial begin
    #(150000 * 5.0);
    n_fail++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic xfer(input logic [1:0] dev, input logic [2:0] dv, input bit q, input bit w,
                      input int len, input bit poke);
    int nw;
    logic [31:0] exp_w;
    nw = (len + 3) / 4;
    x_quad = q; x_wr = w; seed_x = $urandom;
    cap_n = 0; nb = 0; rise_n = 0; done_n = 0; rp = 0; acc = 8'd0;
    sio_in = w ? 4'h0 : chunk(0);
    for (int i = 0; i < 16; i++) wdat[i] = $urandom;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_ctrl = {1'b1, 1'b0, w, q, 4'h0, dev, 3'b000, dv};
    cfg_len = 21'(len);
    @(negedge clk);
    cfg_we = 1'b0;
    check(busy === 1'b1, "R1 busy after start", busy, 1);
    check(cs_n === ~(4'b0001 << dev) && cs_active === 1'b1, "R8 select at start", cs_n, ~(4'b0001 << dev));
    check(sio_oe === (w ? (q ? 4'hF : 4'h1) : 4'h0), "R9 output enable", sio_oe, w ? (q ? 4'hF : 4'h1) : 4'h0);
    check(fifo_busy === !w, "R6 fifo_busy at start", fifo_busy, !w);
    if (poke) begin
      cfg_we = 1'b1; cfg_ctrl = {1'b1, 1'b0, w, q, 4'h0, dev, 3'b000, dv}; cfg_len = 21'(len + 5);
      cs_clr = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; cs_clr = 1'b0;
    end
    if (w) begin
      repeat (10) @(negedge clk);
      if (len > 0) check(rise_n == 0, "R6 sclk held without word", rise_n, 0);
      for (int k = 0; k < nw; k++) begin
        while (fifo_busy) @(negedge clk);
        data_push = 1'b1; data_in = wdat[k];
        @(negedge clk);
        data_push = 1'b0;
        if (k == 0) check(fifo_busy === 1'b1, "R6 fifo_busy after push", fifo_busy, 1);
      end
    end else begin
      for (int k = 0; k < nw; k++) begin
        while (fifo_busy) @(negedge clk);
        exp_w = 32'd0;
        for (int j = 0; j < 4; j++)
          if (4 * k + j < len) exp_w[8*j +: 8] = src(4 * k + j);
        check(data_out === exp_w, q ? "R4/R5 read word quad" : "R3/R5 read word", data_out, exp_w);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        data_pop = 1'b1;
        @(negedge clk);
        data_pop = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(done_n == 1, "R7 done pulse count", done_n, 1);
    if (w) begin
      check(cap_n == len, "R5 bytes clocked", cap_n, len);
      for (int i = 0; i < len && i < 64; i++)
        check(cap[i] === wdat[i/4][8*(i%4) +: 8], q ? "R4 write byte quad" : "R3 write byte", cap[i], wdat[i/4][8*(i%4) +: 8]);
    end else begin
      check(rise_n == len * (q ? 2 : 8), "R5 read clock count", rise_n, len * (q ? 2 : 8));
    end
    if (len == 0) check(rise_n == 0, "R7 zero count no sclk", rise_n, 0);
    if (len > 0) check(rise_t1 - rise_t0 == (2 << dv), "R2 sclk period", rise_t1 - rise_t0, 2 << dv);
    check(sclk === 1'b0, "R2 sclk idle low", sclk, 0);
    check(cs_n === ~(4'b0001 << dev) && cs_active === 1'b1, "R8 select held after done", cs_n, ~(4'b0001 << dev));
    cs_clr = 1'b1;
    @(negedge clk);
    cs_clr = 1'b0;
    check(cs_n === 4'hF && cs_active === 1'b0, "R8 deselect", cs_n, 4'hF);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && sclk === 1'b0 && done === 1'b0, "R7 reset idle", {busy, sclk, done}, 0);
    check(cs_n === 4'hF && cs_active === 1'b0, "R8 reset deselected", cs_n, 4'hF);
    check(fifo_busy === 1'b1 && sio_oe === 4'h0, "R6 reset fifo_busy", {fifo_busy, sio_oe}, 5'h10);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(2'd0, 3'd0, 1'b0, 1'b1, 0, 1'b0);
    xfer(2'd1, 3'd1, 1'b0, 1'b0, 0, 1'b0);
    xfer(2'd2, 3'd0, 1'b1, 1'b1, 5, 1'b1);
    xfer(2'd3, 3'd1, 1'b0, 1'b0, 1, 1'b0);
    xfer(2'd1, 3'd3, 1'b0, 1'b1, 4, 1'b0);
    xfer(2'd0, 3'd2, 1'b1, 1'b0, 7, 1'b1);
    for (int t = 0; t < 24; t++)
      xfer(2'($urandom_range(0, 3)), 3'($urandom_range(0, 2)), 1'($urandom), 1'($urandom),
           $urandom_range(0, 11), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule